// File: doc/BRIEF.md
# Loop-Capable ROM Micro-Sequencer

This block steps through a 128-word program of 36-bit instructions held in a small on-chip store. On every clock it presents the control field of the current word to the datapath it drives. The datapath itself lies outside the block. Program flow is set by three kinds of control instruction: a conditional jump that tests one of the condition inputs, a halt, and a hardware counted loop.

A loop instruction names the first and last addresses of its body and gives an iteration count. From then on the body repeats with no decrement or test instruction inside it. The hardware compares the program counter against the end address of the innermost active loop. When they match, it either returns to the body start or leaves the loop, and it spends no extra cycle doing so. Loop contexts are kept on a small stack so that loops can nest. When several loops share one end address, they all resolve in the same cycle.

The program is written through a load port while reset is held high, so no initialisation file is needed. Reset then starts execution at address 0.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high the program counter is held at 0. In the first cycle after `rst` falls, `ctrl_o` shows bits [32:0] of word 0 and `stk_err_o` is 0.
- R2: While `rst` is high and `load_en` is high, `load_data` is written to word `load_addr`, one word per clock. When `rst` is low, `load_en` has no effect on the stored program.
- R3: `ctrl_o` always equals bits [32:0] of the word at the program counter. A plain instruction advances the counter by one, and the counter wraps from 127 to 0.
- R4: The opcode is bits [35:33], encoded as 0 plain, 1 loop, 2 jump and 3 halt. Codes 4 to 7 behave exactly like the plain opcode.
- R5: A jump word takes its target from bits [6:0] and its condition select from bits [8:7]. If `cond_i[select]` is high in the cycle the jump is current, the next address is the target. Otherwise the word behaves like a plain instruction.
- R6: A loop word takes its end address from bits [6:0], its start address from bits [13:7] and its count N from bits [21:14]. For N > 0 the next address is the start, and the body runs N times back to back with no extra cycles.
- R7: A loop word with N = 0 runs no body and continues at the end address plus one.
- R8: Up to 4 loops can be active at once. When the final pass of an inner loop reaches an end address that an outer loop shares, the outer loop is resolved in the same cycle, either by repeating or by also exiting.
- R9: A loop word issued while 4 loops are active sets `stk_err_o`, which stays high until reset. The loop is not recorded, and execution continues at its start address, so the body runs once.
- R10: While a halt word is current, `halt_o` is high and the counter and `ctrl_o` hold until reset.
- R11: A taken jump has priority over loop-end handling at the same address and leaves the loop stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| cond_i | input | 4 | Condition flags tested by jump words |
| load_en | input | 1 | Program write strobe (used only during reset) |
| load_addr | input | 7 | Program word address to write |
| load_data | input | 36 | Program word to write |
| ctrl_o | output | 33 | Control field of the current instruction |
| halt_o | output | 1 | High while a halt word is current |
| stk_err_o | output | 1 | Sticky loop-stack overflow flag |

## Verification
A wrong loop count, a stale stack pointer or a missed pop does not stay hidden. The next time the counter passes that end address, `ctrl_o` shows a word from the wrong address, so the fault appears within one body length. Faults in the outer-loop cascade on a shared end address appear in the cycle right after that address. A mishandled overflow push shows up as `stk_err_o` at once, or as a wrong word when the shared end is reached. The bench predicts every address from its own model and compares `ctrl_o`, `halt_o` and `stk_err_o` on every cycle, so any divergence is reported at the cycle it first occurs.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // instruction format (fixed)
  localparam int AW     = 7;
  localparam int WORD_W = 36;
  localparam int OP_W   = 3;
  localparam int CNT_W  = 8;
  localparam int CTRL_W = WORD_W - OP_W;

  localparam int OP_LSB   = WORD_W - OP_W;
  localparam int END_LSB  = 0;
  localparam int BEG_LSB  = END_LSB + AW;
  localparam int CNT_LSB  = BEG_LSB + AW;
  localparam int TGT_LSB  = 0;
  localparam int SEL_LSB  = TGT_LSB + AW;

  localparam logic [OP_W-1:0] OP_NOP  = 3'd0;
  localparam logic [OP_W-1:0] OP_FOR  = 3'd1;
  localparam logic [OP_W-1:0] OP_BR   = 3'd2;
  localparam logic [OP_W-1:0] OP_HALT = 3'd3;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // single clock, registered read: maps to a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_loopstk.sv
module useq_loopstk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_beg,
  input  logic [ADDR_W-1:0] push_end,
  input  logic [CNT_W-1:0]  push_cnt,
  input  logic              chk_en,
  input  logic [ADDR_W-1:0] pc,
  output logic              jump,
  output logic [ADDR_W-1:0] jump_to,
  output logic              err
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] ent_beg [DEPTH];
  logic [ADDR_W-1:0] ent_end [DEPTH];
  logic [CNT_W-1:0]  ent_cnt [DEPTH];
  logic [SPW-1:0]    sp, sp_nx;
  logic [IW-1:0]     dec_idx;
  logic              done;
  logic              full;

  assign full = (sp == SPW'(DEPTH));

  // scan from the innermost context outward; contexts on their last pass
  // at this end address are popped, the first with passes left repeats
  always_comb begin
    jump    = 1'b0;
    jump_to = '0;
    sp_nx   = sp;
    dec_idx = '0;
    done    = 1'b0;
    if (chk_en) begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (!done && (i < int'(sp))) begin
          if (ent_end[i] == pc) begin
            if (ent_cnt[i] > CNT_W'(1)) begin
              jump    = 1'b1;
              jump_to = ent_beg[i];
              dec_idx = IW'(i);
              done    = 1'b1;
            end else begin
              sp_nx = SPW'(i);
            end
          end else begin
            done = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      err <= 1'b0;
    end else if (push_en) begin
      if (full) begin
        err <= 1'b1;
      end else begin
        ent_beg[sp[IW-1:0]] <= push_beg;
        ent_end[sp[IW-1:0]] <= push_end;
        ent_cnt[sp[IW-1:0]] <= push_cnt;
        sp <= sp + 1'b1;
      end
    end else if (chk_en) begin
      sp <= sp_nx;
      if (jump) ent_cnt[dec_idx] <= ent_cnt[dec_idx] - 1'b1;
    end
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_full_push_R9: assert property (@(posedge clk) disable iff (rst)
    (push_en && full) |=> (full && err));

  assert_push_grows_R8: assert property (@(posedge clk) disable iff (rst)
    (push_en && !full) |=> (sp == $past(sp) + 1'b1));

  assert_jump_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    jump |=> (sp != '0));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int COND_N      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_N-1:0] cond_i,
  input  logic              load_en,
  input  logic [AW-1:0]     load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              halt_o,
  output logic              stk_err_o
);
  localparam int SEL_W = (COND_N > 1) ? $clog2(COND_N) : 1;

  logic [AW-1:0]     pc, pc_nx, pc_inc;
  logic [WORD_W-1:0] ir;
  logic [OP_W-1:0]   op;
  logic [AW-1:0]     f_end, f_beg, f_tgt;
  logic [CNT_W-1:0]  f_cnt;
  logic [SEL_W-1:0]  f_sel;
  logic              push_en, chk_en, taken;
  logic              lp_jump;
  logic [AW-1:0]     lp_to;

  useq_store #(.ADDR_W(AW), .DATA_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (rst & load_en),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (pc_nx),
    .rdata (ir)
  );

  assign op    = ir[OP_LSB +: OP_W];
  assign f_end = ir[END_LSB +: AW];
  assign f_beg = ir[BEG_LSB +: AW];
  assign f_cnt = ir[CNT_LSB +: CNT_W];
  assign f_tgt = ir[TGT_LSB +: AW];
  assign f_sel = ir[SEL_LSB +: SEL_W];

  useq_loopstk #(.DEPTH(STACK_DEPTH), .ADDR_W(AW), .CNT_W(CNT_W)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push_en  (push_en),
    .push_beg (f_beg),
    .push_end (f_end),
    .push_cnt (f_cnt),
    .chk_en   (chk_en),
    .pc       (pc),
    .jump     (lp_jump),
    .jump_to  (lp_to),
    .err      (stk_err_o)
  );

  // next address also feeds the store read port, so ir tracks mem[pc]
  always_comb begin
    push_en = 1'b0;
    chk_en  = 1'b0;
    taken   = 1'b0;
    pc_inc  = pc + 1'b1;
    pc_nx   = pc_inc;
    if (rst) begin
      pc_nx = '0;
    end else begin
      case (op)
        OP_HALT: pc_nx = pc;
        OP_FOR: begin
          if (f_cnt == '0) begin
            pc_nx = f_end + 1'b1;
          end else begin
            push_en = 1'b1;
            pc_nx   = f_beg;
          end
        end
        OP_BR: begin
          if (cond_i[f_sel]) begin
            taken = 1'b1;
            pc_nx = f_tgt;
          end else begin
            chk_en = 1'b1;
            pc_nx  = lp_jump ? lp_to : pc_inc;
          end
        end
        default: begin
          chk_en = 1'b1;
          pc_nx  = lp_jump ? lp_to : pc_inc;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nx;
  end

  assign ctrl_o = ir[CTRL_W-1:0];
  assign halt_o = (op == OP_HALT);

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc == '0));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> (halt_o && $stable(ctrl_o) && $stable(pc)));

  assert_skip_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FOR && f_cnt == '0) |=> (pc == $past(f_end) + 1'b1));

  assert_for_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FOR && f_cnt != '0) |=> (pc == $past(f_beg)));

  assert_branch_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BR && cond_i[f_sel]) |=> (pc == $past(f_tgt)));
endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond_i = '0;
  logic        load_en = 1'b0;
  logic [6:0]  load_addr = '0;
  logic [35:0] load_data = '0;
  logic [32:0] ctrl_o;
  logic        halt_o, stk_err_o;

  always #2 clk = ~clk;

  useq_top uut (
    .clk(clk), .rst(rst), .cond_i(cond_i), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data),
    .ctrl_o(ctrl_o), .halt_o(halt_o), .stk_err_o(stk_err_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [35:0] mem [128];
  bit poked [128];
  int m_pc;
  int qb[$], qe[$], qn[$];
  bit m_err;
  string why;

  function automatic logic [35:0] w_nop(int tag);
    return {3'd0, 1'b0, tag[31:0]};
  endfunction
  function automatic logic [35:0] w_odd(int tag);
    return {3'd5, 1'b0, tag[31:0]};
  endfunction
  function automatic logic [35:0] w_for(int b, int e, int n);
    return {3'd1, 11'd0, n[7:0], b[6:0], e[6:0]};
  endfunction
  function automatic logic [35:0] w_br(int sel, int tgt);
    return {3'd2, 24'd0, sel[1:0], tgt[6:0]};
  endfunction
  function automatic logic [35:0] w_halt();
    return {3'd3, 33'd0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    t = poked[m_pc] ? {why, " R2"} : why;
    chk(t, 64'(ctrl_o), 64'(mem[m_pc][32:0]));
    chk({t, " R10"}, 64'(halt_o), 64'(mem[m_pc][35:33] == 3'd3));
    chk("R9", 64'(stk_err_o), 64'(m_err));
  endtask

  // behavioural reference: one instruction per call
  task automatic model_next(logic [3:0] c);
    logic [35:0] w;
    int op, e, b, n;
    bit popped, jumped;
    w  = mem[m_pc];
    op = int'(w[35:33]);
    e  = int'(w[6:0]);
    b  = int'(w[13:7]);
    n  = int'(w[21:14]);
    if (op == 3) begin
      why = "R10";
    end else if (op == 1) begin
      if (n == 0) begin
        m_pc = (e + 1) % 128; why = "R7";
      end else if (qb.size() == 4) begin
        m_err = 1; m_pc = b; why = "R9";
      end else begin
        qb.push_back(b); qe.push_back(e); qn.push_back(n);
        m_pc = b; why = "R6";
      end
    end else if (op == 2 && c[w[8:7]]) begin
      why = (qe.size() > 0 && qe[$] == m_pc) ? "R11" : "R5";
      m_pc = int'(w[6:0]);
    end else begin
      popped = 0; jumped = 0;
      while (qe.size() > 0 && qe[$] == m_pc && !jumped) begin
        if (qn[$] > 1) begin
          qn[$] = qn[$] - 1;
          m_pc = qb[$];
          jumped = 1;
        end else begin
          void'(qb.pop_back()); void'(qe.pop_back()); void'(qn.pop_back());
          popped = 1;
        end
      end
      if (!jumped) m_pc = (m_pc + 1) % 128;
      if (popped)           why = "R8";
      else if (jumped)      why = "R6";
      else if (op >= 4)     why = "R4";
      else if (op == 2)     why = "R5";
      else if (m_pc == 0)   why = "R3 wrap";
      else                  why = "R3";
    end
  endtask

  task automatic load(int a, logic [35:0] d);
    load_en = 1'b1; load_addr = a[6:0]; load_data = d;
    @(negedge clk);
    mem[a] = d;
    load_en = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_err = 0;
    qb.delete(); qe.delete(); qn.delete();
    why = "R1";
  endtask

  task automatic run(logic [3:0] c0, logic [3:0] crest, bit poke);
    int halts;
    halts = 0;
    for (int i = 0; i < 400 && halts < 3; i++) begin
      cond_i = (i == 0) ? c0 : crest;
      if (poke && i == 2) begin
        load_en = 1'b1; load_addr = 7'd11; load_data = w_halt();
        poked[11] = 1;
      end else begin
        load_en = 1'b0;
      end
      compare();
      if (mem[m_pc][35:33] == 3'd3) halts++;
      model_next(cond_i);
      @(negedge clk);
    end
    load_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) poked[i] = 0;
    @(negedge clk);
    for (int i = 0; i < 128; i++) load(i, w_nop(i * 7 + 1));
    load(1,  w_for(2, 4, 3));
    load(2,  w_for(3, 4, 2));
    load(5,  w_for(6, 8, 0));
    load(9,  w_br(1, 12));
    load(10, w_odd(77));
    load(12, w_for(13, 14, 2));
    load(14, w_br(0, 20));
    load(15, w_for(16, 16, 5));
    load(17, w_for(18, 30, 1));
    load(18, w_for(19, 30, 1));
    load(19, w_for(20, 30, 1));
    load(20, w_for(21, 30, 1));
    load(21, w_for(22, 30, 2));
    load(31, w_for(32, 33, 2));
    load(33, w_br(2, 40));
    load(40, w_halt());
    // run 1: jump at 9 not taken, store write attempted while running
    start_run();
    run(4'b0100, 4'b0100, 1'b1);
    // run 2: reset clears the error flag, jump at 9 taken
    start_run();
    run(4'b0110, 4'b0110, 1'b0);
    // run 3: jump from word 0 to 125, wrap through 127 back to 0
    load(0, w_br(3, 125));
    start_run();
    run(4'b1000, 4'b0110, 1'b0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule